// File: doc/BRIEF.md
# Weighted Push-Button Tally

This block keeps a running binary total that grows by a fixed weight each time one of three push buttons is pressed. The buttons are active low. The least significant button adds one, the middle button adds ten and the most significant button adds a hundred. The raw button vector is first captured into the clock domain. A second register then keeps the previous captured value. The total moves only in the cycle in which these two registers differ. A press therefore counts once, however long the button is held down.

A synchronous, active-high reset clears the total and lights a status LED. The total is also decoded combinationally into four BCD digits, which can drive a decimal display. Debounce filtering and display segment encoding belong to other blocks.

Top module: `press_tally`

## Requirements
- R1: The button vector `btn_n` is active low. Pattern 3'b110 selects weight 1, pattern 3'b101 selects weight 10 and pattern 3'b011 selects weight 100.
- R2: Every other captured pattern selects weight 0. This covers 3'b111 (nothing pressed) and any pattern with two or more bits low.
- R3: The raw input passes through a capture register and then a previous-value register. A change in `btn_n` that is set up before rising edge k appears in `sum` after rising edge k+1, and not after edge k.
- R4: While the captured pattern stays the same, `sum` holds its value. A button held for many cycles adds its weight exactly once.
- R5: Releasing a button, which returns the pattern to 3'b111, adds nothing.
- R6: Moving straight from one single-button pattern to another single-button pattern adds the weight of the new pattern.
- R7: When `rst` is high at a rising edge, `sum` becomes 0. This takes priority over any increment due at that edge.
- R8: `led` is registered. It reads 1 after any edge at which `rst` was high, and 0 after any edge at which `rst` was low.
- R9: While `rst` is high, both button registers load the live input. A button held through reset is therefore not counted when reset is released.
- R10: `sum` is 16 bits wide and wraps modulo 65536.
- R11: The digits `dig_th`, `dig_hu`, `dig_te` and `dig_on` are a combinational shift-and-add-3 conversion of `sum`. The three lower digits always equal the low three decimal digits of `sum`. All four digits together equal `sum` whenever `sum` is at most 9999.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| btn_n | input | 3 | Raw active-low buttons: bit 0 adds 1, bit 1 adds 10, bit 2 adds 100 |
| led | output | 1 | Registered reset indicator |
| sum | output | 16 | Running total |
| dig_th | output | 4 | BCD thousands digit |
| dig_hu | output | 4 | BCD hundreds digit |
| dig_te | output | 4 | BCD tens digit |
| dig_on | output | 4 | BCD ones digit |

## Verification
A button change reaches `sum` two rising edges after it is driven. The BCD digits follow `sum` in the same cycle. `led` follows `rst` one edge later. The bench drives its inputs on falling edges and samples on falling edges. In the latency test it checks `sum` one falling edge after the change, to confirm no update yet, and again one falling edge later, where the new value is due. Every other press holds its pattern for three cycles and then releases for three cycles, so both the add and the release have settled before the total is compared.

// File: rtl/press_tally_pkg.sv
package press_tally_pkg;
  localparam int SUM_W = 16;
  localparam int BTN_N = 3;
  localparam int DIG_N = 4;
  localparam int BCD_W = DIG_N * 4;

  // Weight for a captured active-low pattern: exactly one low bit i gives 10**i.
  function automatic logic [SUM_W-1:0] weight_of(input logic [BTN_N-1:0] pat_n);
    logic [SUM_W-1:0] w;
    logic [SUM_W-1:0] scale;
    w     = '0;
    scale = SUM_W'(1);
    for (int i = 0; i < BTN_N; i++) begin
      if (pat_n == ~(BTN_N'(1) << i)) w = scale;
      scale = SUM_W'(scale * SUM_W'(10));
    end
    return w;
  endfunction

  // Shift-and-add-3 over all bits of the binary value.
  function automatic logic [BCD_W-1:0] dabble(input logic [SUM_W-1:0] bin);
    logic [BCD_W-1:0] acc;
    acc = '0;
    for (int b = SUM_W - 1; b >= 0; b--) begin
      for (int d = 0; d < DIG_N; d++) begin
        if (acc[d*4 +: 4] >= 4'd5) acc[d*4 +: 4] = acc[d*4 +: 4] + 4'd3;
      end
      acc = {acc[BCD_W-2:0], bin[b]};
    end
    return acc;
  endfunction
endpackage

// File: rtl/press_tally_sync.sv
module press_tally_sync
  import press_tally_pkg::*;
#(
  parameter int N = BTN_N
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] btn_n,
  output logic [N-1:0] samp_now,
  output logic [N-1:0] samp_prev
);
  always_ff @(posedge clk) begin
    samp_now <= btn_n;
    if (rst) samp_prev <= btn_n;
    else     samp_prev <= samp_now;
  end
endmodule

// File: rtl/press_tally_step.sv
module press_tally_step
  import press_tally_pkg::*;
#(
  parameter int N = BTN_N,
  parameter int W = SUM_W
) (
  input  logic [N-1:0] samp_now,
  input  logic [N-1:0] samp_prev,
  output logic         press_edge,
  output logic [W-1:0] step
);
  always_comb begin
    press_edge = (samp_now != samp_prev);
    step       = press_edge ? W'(weight_of(samp_now)) : '0;
  end
endmodule

// File: rtl/press_tally_acc.sv
module press_tally_acc
  import press_tally_pkg::*;
#(
  parameter int W = SUM_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] step,
  output logic [W-1:0] total,
  output logic         led
);
  always_ff @(posedge clk) begin
    led <= rst;
    if (rst) total <= '0;
    else     total <= total + step;
  end
endmodule

// File: rtl/press_tally_bcd.sv
module press_tally_bcd
  import press_tally_pkg::*;
(
  input  logic [SUM_W-1:0] bin,
  output logic [3:0]       digit [DIG_N]
);
  logic [BCD_W-1:0] packed_bcd;
  assign packed_bcd = dabble(bin);
  for (genvar d = 0; d < DIG_N; d++) begin : g_dig
    assign digit[d] = packed_bcd[d*4 +: 4];
  end
endmodule

// File: rtl/press_tally.sv
module press_tally
  import press_tally_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [BTN_N-1:0] btn_n,
  output logic             led,
  output logic [SUM_W-1:0] sum,
  output logic [3:0]       dig_th,
  output logic [3:0]       dig_hu,
  output logic [3:0]       dig_te,
  output logic [3:0]       dig_on
);
  logic [BTN_N-1:0] samp_now;
  logic [BTN_N-1:0] samp_prev;
  logic             press_edge;
  logic [SUM_W-1:0] step;
  logic [3:0]       digit [DIG_N];

  press_tally_sync #(.N(BTN_N)) u_sync (
    .clk(clk), .rst(rst), .btn_n(btn_n),
    .samp_now(samp_now), .samp_prev(samp_prev)
  );

  press_tally_step #(.N(BTN_N), .W(SUM_W)) u_step (
    .samp_now(samp_now), .samp_prev(samp_prev),
    .press_edge(press_edge), .step(step)
  );

  press_tally_acc #(.W(SUM_W)) u_acc (
    .clk(clk), .rst(rst), .step(step), .total(sum), .led(led)
  );

  press_tally_bcd u_bcd (.bin(sum), .digit(digit));

  assign dig_on = digit[0];
  assign dig_te = digit[1];
  assign dig_hu = digit[2];
  assign dig_th = digit[3];
endmodule

// File: rtl/press_tally_chk.sv
module press_tally_chk
  import press_tally_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             led,
  input logic [SUM_W-1:0] sum,
  input logic [BTN_N-1:0] samp_now,
  input logic [BTN_N-1:0] samp_prev,
  input logic             press_edge,
  input logic [3:0]       dig_th,
  input logic [3:0]       dig_hu,
  input logic [3:0]       dig_te,
  input logic [3:0]       dig_on
);
  // R4: an unchanged capture leaves the total alone
  p_hold_still_r4: assert property (@(posedge clk) disable iff (rst)
    (samp_now == samp_prev) |=> (sum == $past(sum)));

  // R1 R2 R10: each update adds 0, 1, 10 or 100, modulo 2**16
  p_step_legal_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((SUM_W'(sum - $past(sum)) == SUM_W'(0))  ||
              (SUM_W'(sum - $past(sum)) == SUM_W'(1))  ||
              (SUM_W'(sum - $past(sum)) == SUM_W'(10)) ||
              (SUM_W'(sum - $past(sum)) == SUM_W'(100))));

  // R5: release pattern adds nothing
  p_release_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (press_edge && (samp_now == '1)) |=> (sum == $past(sum)));

  // R8: led off one edge after a non-reset edge
  p_led_off_r8: assert property (@(posedge clk) disable iff (rst)
    !rst |=> !led);

  // R11: lower digits stay decimal
  p_low_digits_r11: assert property (@(posedge clk) disable iff (rst)
    (dig_on <= 4'd9) && (dig_te <= 4'd9) && (dig_hu <= 4'd9));

  // R11: full value matches below 10000
  p_value_r11: assert property (@(posedge clk) disable iff (rst)
    (sum <= SUM_W'(9999)) |->
      ((32'(dig_th) * 1000 + 32'(dig_hu) * 100 + 32'(dig_te) * 10 + 32'(dig_on)) == 32'(sum)));
endmodule

bind press_tally press_tally_chk u_chk (
  .clk(clk), .rst(rst), .led(led), .sum(sum),
  .samp_now(samp_now), .samp_prev(samp_prev), .press_edge(press_edge),
  .dig_th(dig_th), .dig_hu(dig_hu), .dig_te(dig_te), .dig_on(dig_on)
);

// File: tb/press_tally_tb.sv
module press_tally_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  btn_n = 3'b111;
  logic        led;
  logic [15:0] sum;
  logic [3:0]  dig_th, dig_hu, dig_te, dig_on;

  int n_checks = 0;
  int n_fail   = 0;
  int expect_sum = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  press_tally u_dut (
    .clk(clk), .rst(rst), .btn_n(btn_n), .led(led), .sum(sum),
    .dig_th(dig_th), .dig_hu(dig_hu), .dig_te(dig_te), .dig_on(dig_on)
  );

  // pattern / weight table
  localparam logic [2:0] PAT [8] = '{3'b110, 3'b101, 3'b011, 3'b111,
                                     3'b100, 3'b000, 3'b010, 3'b001};
  localparam int         WGT [8] = '{1, 10, 100, 0, 0, 0, 0, 0};

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_eq(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic press(input logic [2:0] p);
    btn_n = p;
    tick(3);
    btn_n = 3'b111;
    tick(3);
  endtask

  task automatic check_digits(input string tag);
    int v;
    v = int'(sum);
    check_eq({tag, " R11 ones"}, int'(dig_on), v % 10);
    check_eq({tag, " R11 tens"}, int'(dig_te), (v / 10) % 10);
    check_eq({tag, " R11 hundreds"}, int'(dig_hu), (v / 100) % 10);
    if (v <= 9999) check_eq({tag, " R11 thousands"}, int'(dig_th), v / 1000);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick(2);
    rst = 1'b0;
    tick(1);
    expect_sum = 0;
  endtask

  initial begin
    tick(3);
    check_eq("R7 reset sum", int'(sum), 0);
    check_eq("R8 led during reset", int'(led), 1);
    rst = 1'b0;
    tick(1);
    check_eq("R8 led after reset", int'(led), 0);

    // R3 latency: two edges from input to sum
    btn_n = 3'b110;
    tick(1);
    check_eq("R3 no update after one edge", int'(sum), 0);
    tick(1);
    check_eq("R3 update after two edges", int'(sum), 1);
    btn_n = 3'b111;
    tick(3);
    check_eq("R5 release adds nothing", int'(sum), 1);
    expect_sum = 1;

    // table walk (R1 weights, R2 zero patterns)
    for (int i = 0; i < 8; i++) begin
      press(PAT[i]);
      expect_sum += WGT[i];
      check_eq((WGT[i] != 0) ? "R1 weighted press" : "R2 zero pattern", int'(sum), expect_sum);
    end
    check_digits("mid");

    // R4 long hold counts once
    btn_n = 3'b101;
    tick(25);
    expect_sum += 10;
    check_eq("R4 held button counted once", int'(sum), expect_sum);
    btn_n = 3'b111;
    tick(3);
    check_eq("R5 release after hold", int'(sum), expect_sum);

    // R6 direct switch between buttons
    btn_n = 3'b110;
    tick(3);
    btn_n = 3'b011;
    tick(3);
    expect_sum += 101;
    check_eq("R6 direct switch", int'(sum), expect_sum);
    btn_n = 3'b111;
    tick(3);
    check_eq("R6 release after switch", int'(sum), expect_sum);

    // R7 priority: increment due on the same edge as reset
    btn_n = 3'b110;
    tick(1);
    rst = 1'b1;
    tick(1);
    check_eq("R7 reset beats increment", int'(sum), 0);
    check_eq("R8 led on", int'(led), 1);
    rst = 1'b0;
    tick(4);
    check_eq("R9 held through reset not counted", int'(sum), 0);
    btn_n = 3'b111;
    tick(3);
    check_eq("R9 release after reset", int'(sum), 0);
    press(3'b110);
    check_eq("R9 press after reset", int'(sum), 1);

    // 9999 boundary
    do_reset();
    for (int i = 0; i < 99; i++) press(3'b011);
    for (int i = 0; i < 9; i++) press(3'b101);
    for (int i = 0; i < 9; i++) press(3'b110);
    check_eq("R11 reach 9999", int'(sum), 9999);
    check_digits("9999");
    press(3'b110);
    check_eq("R11 reach 10000", int'(sum), 10000);
    check_digits("10000");

    // R10 wrap
    do_reset();
    for (int i = 0; i < 655; i++) press(3'b011);
    check_eq("R10 reach 65500", int'(sum), 65500);
    check_digits("65500");
    for (int i = 0; i < 36; i++) press(3'b110);
    check_eq("R10 wrap to zero", int'(sum), 0);
    press(3'b110);
    check_eq("R10 count after wrap", int'(sum), 1);
    check_digits("after wrap");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule